// File: doc/BRIEF.md
# Register Renamer with Free-Register Pool and Branch Snapshots

This block sits between decode and scheduling. Each cycle it accepts a group of up to `GROUP` instructions. Each instruction carries two logical source registers, a logical destination and a flag that says whether the destination is written. For every slot the block returns three tags within the same cycle: the physical tags of both sources, a freshly allocated physical tag for the destination, and the physical tag that the destination was mapped to before. The mapping state is a table with one physical tag per logical register. Spare physical registers sit in a circular pool that is allocated from the front and refilled at the back.

Slots are handled in program order, so a later slot sees what earlier slots in the same group wrote. An old destination tag goes back to the pool only when the instruction that replaced it retires, and the retirement logic returns it on the `ret_*` inputs. A slot flagged as a conditional branch saves a snapshot of the mapping and of the pool read position into a checkpoint slot. A misprediction rolls both back from that snapshot. Checkpoints are kept in age order: a correctly resolved branch releases the oldest one, and a recovery discards the chosen checkpoint together with every younger one. The numbers of logical registers, physical registers and checkpoints must be powers of two.

Top module: `reg_rename`

## Requirements
- R1: After reset, logical register i maps to physical register i. The free pool holds physical registers NUM_LOG up to NUM_PHYS-1, handed out in ascending order.
- R2: In the cycle a group is presented, each source tag equals the mapping table entry of that logical register, including entries written by groups accepted earlier.
- R3: Within a group, a source or old-destination lookup in slot j returns the tag allocated to the nearest earlier slot (lower index) that writes the same logical register.
- R4: Each slot with `ren_dst_en` set receives the next tag from the pool front, slot 0 first. It also reports the destination's previous mapping in `out_pold`. The destination's mapping then becomes the new tag, and the tags given out in one group are all different.
- R5: A slot with `ren_dst_en` clear consumes no pool entry and leaves the mapping unchanged, whatever its `ren_dst` field holds.
- R6: `ren_ready` is low whenever the pool holds fewer tags than the group's count of set `ren_dst_en` bits. While the block is not accepting, neither the mapping nor the pool changes.
- R7: Tags presented with `ret_en` join the back of the pool, slot 0 first, and are allocated after every tag that was already free.
- R8: A group with a branch slot (at most one per group) stores a snapshot of the mapping after that slot, and of the pool read position after that slot's allocation. It reports the checkpoint index in `out_ckpt_id`, with indices handed out in circular order. `ren_ready` is low for such a group while all NUM_CKPT checkpoints are held.
- R9: With `rec_en` high, `ren_ready` is low. On the next cycle the mapping equals the snapshot of checkpoint `rec_id`, and the tags allocated after that branch come out of the pool again first, in their original order.
- R10: A `br_free` pulse releases the oldest held checkpoint. A recovery to `rec_id` releases that checkpoint and all younger ones, while older ones stay held. `br_free` has no effect in a cycle with `rec_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ren_valid | input | 1 | A rename group is presented |
| ren_ready | output | 1 | The presented group is accepted this cycle |
| ren_src_a | input | GROUP*LW | First logical source per slot |
| ren_src_b | input | GROUP*LW | Second logical source per slot |
| ren_dst | input | GROUP*LW | Logical destination per slot |
| ren_dst_en | input | GROUP | Slot writes its destination |
| ren_branch | input | GROUP | Slot is a conditional branch (at most one set) |
| out_psrc_a | output | GROUP*PW | Physical tag of first source |
| out_psrc_b | output | GROUP*PW | Physical tag of second source |
| out_pdst | output | GROUP*PW | Newly allocated destination tag |
| out_pold | output | GROUP*PW | Previous mapping of the destination |
| out_ckpt_id | output | CW | Checkpoint index given to this group's branch |
| ret_en | input | GROUP | Retirement slot returns a tag |
| ret_tag | input | GROUP*PW | Tag returned to the pool |
| br_free | input | 1 | Oldest branch resolved correctly |
| rec_en | input | 1 | Misprediction recovery |
| rec_id | input | CW | Checkpoint to restore |

## Verification
The bench builds the block with 8 logical registers, 16 physical registers, a group width of 2 and 2 checkpoints. With these values the pool of 8 spare tags runs dry after a few groups, so the allocation stall and refill-by-retirement paths are reached often. Both checkpoint slots fill after two branches, which exercises the checkpoint-full stall. Recovery can then target either the oldest or the younger checkpoint.

// File: rtl/rn_pkg.sv
package rn_pkg;

    localparam int unsigned DEF_LOG_REGS  = 32;
    localparam int unsigned DEF_PHYS_REGS = 64;
    localparam int unsigned DEF_GROUP     = 4;
    localparam int unsigned DEF_CKPTS     = 4;

    // index width for a table of n entries, never below one bit
    function automatic int unsigned bits_for(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

    // why a presented group is not accepted
    typedef enum logic [1:0] {
        ST_GO      = 2'd0,
        ST_NO_REGS = 2'd1,
        ST_NO_CKPT = 2'd2,
        ST_RECOVER = 2'd3
    } stall_e;

endpackage

// File: rtl/rn_free_list.sv
module rn_free_list import rn_pkg::*; #(
    parameter int unsigned NUM_LOG  = DEF_LOG_REGS,
    parameter int unsigned NUM_PHYS = DEF_PHYS_REGS,
    parameter int unsigned GROUP    = DEF_GROUP,
    localparam int unsigned PW      = bits_for(NUM_PHYS),
    localparam int unsigned CNTW    = PW + 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [GROUP-1:0]            push_en,
    input  logic [GROUP-1:0][PW-1:0]    push_tag,
    input  logic [CNTW-1:0]             pop_n,
    input  logic                        restore_en,
    input  logic [CNTW-1:0]             restore_head,
    output logic [GROUP-1:0][PW-1:0]    peek,
    output logic [CNTW-1:0]             head_ptr,
    output logic [CNTW-1:0]             free_cnt
);

    localparam int unsigned SPARE = NUM_PHYS - NUM_LOG;

    logic [NUM_PHYS-1:0][PW-1:0] slots;
    logic [CNTW-1:0]             head_q;
    logic [CNTW-1:0]             tail_q;
    logic [GROUP-1:0][PW-1:0]    widx;
    logic [CNTW-1:0]             push_total;

    assign head_ptr = head_q;
    assign free_cnt = tail_q - head_q;

    for (genvar j = 0; j < GROUP; j++) begin : g_peek
        assign peek[j] = slots[head_q[PW-1:0] + PW'(j)];
    end

    // retired tags are packed at the tail in slot order
    always_comb begin
        logic [CNTW-1:0] off;
        off = '0;
        for (int j = 0; j < GROUP; j++) begin
            widx[j] = tail_q[PW-1:0] + off[PW-1:0];
            if (push_en[j]) off = off + CNTW'(1);
        end
        push_total = off;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NUM_PHYS; k++) begin
                slots[k] <= (k < SPARE) ? PW'(NUM_LOG + k) : '0;
            end
            head_q <= '0;
            tail_q <= CNTW'(SPARE);
        end else begin
            head_q <= restore_en ? restore_head : head_q + pop_n;
            tail_q <= tail_q + push_total;
            for (int j = 0; j < GROUP; j++) begin
                if (push_en[j]) slots[widx[j]] <= push_tag[j];
            end
        end
    end

    // R6: the renamer never takes more tags than the pool holds
    assert_pop_within_R6: assert property (@(posedge clk) disable iff (rst)
        pop_n <= free_cnt)
        else $error("pool underflow");

    // R7: mapped registers are never free, so the pool stays within the spare count
    assert_pool_bound_R7: assert property (@(posedge clk) disable iff (rst)
        free_cnt <= CNTW'(SPARE))
        else $error("pool overflow");

endmodule

// File: rtl/rn_group_xlate.sv
module rn_group_xlate import rn_pkg::*; #(
    parameter int unsigned NUM_LOG  = DEF_LOG_REGS,
    parameter int unsigned NUM_PHYS = DEF_PHYS_REGS,
    parameter int unsigned GROUP    = DEF_GROUP,
    localparam int unsigned LW      = bits_for(NUM_LOG),
    localparam int unsigned PW      = bits_for(NUM_PHYS),
    localparam int unsigned CNTW    = PW + 1
) (
    input  logic [NUM_LOG-1:0][PW-1:0]  map_cur,
    input  logic [GROUP-1:0][LW-1:0]    src_a,
    input  logic [GROUP-1:0][LW-1:0]    src_b,
    input  logic [GROUP-1:0][LW-1:0]    dst,
    input  logic [GROUP-1:0]            dst_en,
    input  logic [GROUP-1:0]            branch,
    input  logic [GROUP-1:0][PW-1:0]    peek,
    input  logic [CNTW-1:0]             head_ptr,
    output logic [GROUP-1:0][PW-1:0]    psrc_a,
    output logic [GROUP-1:0][PW-1:0]    psrc_b,
    output logic [GROUP-1:0][PW-1:0]    pdst,
    output logic [GROUP-1:0][PW-1:0]    pold,
    output logic [NUM_LOG-1:0][PW-1:0]  map_next,
    output logic [CNTW-1:0]             need_cnt,
    output logic                        has_branch,
    output logic [NUM_LOG-1:0][PW-1:0]  snap_map,
    output logic [CNTW-1:0]             snap_head
);

    localparam int unsigned SW = bits_for(GROUP);

    logic [NUM_LOG-1:0][PW-1:0] cur;
    logic [SW:0]                n;

    // walk the slots in program order, each one seeing the earlier writes
    always_comb begin
        cur        = map_cur;
        n          = '0;
        has_branch = 1'b0;
        snap_map   = map_cur;
        snap_head  = head_ptr;
        for (int j = 0; j < GROUP; j++) begin
            psrc_a[j] = cur[src_a[j]];
            psrc_b[j] = cur[src_b[j]];
            pold[j]   = cur[dst[j]];
            pdst[j]   = peek[n[SW-1:0]];
            if (dst_en[j]) begin
                cur[dst[j]] = peek[n[SW-1:0]];
                n           = n + (SW+1)'(1);
            end
            if (branch[j] && !has_branch) begin
                has_branch = 1'b1;
                snap_map   = cur;
                snap_head  = head_ptr + CNTW'(n);
            end
        end
        map_next = cur;
        need_cnt = CNTW'(n);
    end

endmodule

// File: rtl/rn_map_store.sv
module rn_map_store import rn_pkg::*; #(
    parameter int unsigned NUM_LOG  = DEF_LOG_REGS,
    parameter int unsigned NUM_PHYS = DEF_PHYS_REGS,
    parameter int unsigned NUM_CKPT = DEF_CKPTS,
    localparam int unsigned PW      = bits_for(NUM_PHYS),
    localparam int unsigned CNTW    = PW + 1,
    localparam int unsigned CW      = bits_for(NUM_CKPT)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        upd_en,
    input  logic [NUM_LOG-1:0][PW-1:0]  map_next,
    input  logic                        snap_en,
    input  logic [NUM_LOG-1:0][PW-1:0]  snap_map,
    input  logic [CNTW-1:0]             snap_head,
    input  logic                        release_en,
    input  logic                        rec_en,
    input  logic [CW-1:0]               rec_id,
    output logic [NUM_LOG-1:0][PW-1:0]  map_q,
    output logic                        ckpt_full,
    output logic [CW-1:0]               ckpt_id,
    output logic [CNTW-1:0]             rec_head
);

    logic [NUM_LOG-1:0][PW-1:0] ck_map  [NUM_CKPT];
    logic [CNTW-1:0]            ck_head [NUM_CKPT];
    logic [CW-1:0]              ck_old;
    logic [CW:0]                ck_cnt;

    assign ckpt_full = (ck_cnt == (CW+1)'(NUM_CKPT));
    assign ckpt_id   = ck_old + ck_cnt[CW-1:0];
    assign rec_head  = ck_head[rec_id];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_LOG; i++) map_q[i] <= PW'(i);
            for (int c = 0; c < NUM_CKPT; c++) begin
                ck_map[c]  <= '0;
                ck_head[c] <= '0;
            end
            ck_old <= '0;
            ck_cnt <= '0;
        end else if (rec_en) begin
            // drop the restored checkpoint and everything younger
            map_q  <= ck_map[rec_id];
            ck_cnt <= {1'b0, rec_id - ck_old};
        end else begin
            if (upd_en) map_q <= map_next;
            if (snap_en) begin
                ck_map[ckpt_id]  <= snap_map;
                ck_head[ckpt_id] <= snap_head;
            end
            if (release_en) ck_old <= ck_old + CW'(1);
            ck_cnt <= ck_cnt + (CW+1)'(snap_en) - (CW+1)'(release_en);
        end
    end

    // R9: the cycle after recovery the mapping is the saved snapshot
    assert_restore_map_R9: assert property (@(posedge clk) disable iff (rst)
        rec_en |=> map_q == $past(ck_map[rec_id]))
        else $error("restore mismatch");

    // R8: never more checkpoints held than slots exist
    assert_ckpt_bound_R8: assert property (@(posedge clk) disable iff (rst)
        ck_cnt <= (CW+1)'(NUM_CKPT))
        else $error("checkpoint count overflow");

    // R8: no snapshot is written into a full store
    assert_no_snap_full_R8: assert property (@(posedge clk) disable iff (rst)
        snap_en |-> !ckpt_full)
        else $error("snapshot while full");

    // R10: a release only targets a held checkpoint
    assert_release_held_R10: assert property (@(posedge clk) disable iff (rst)
        (release_en && !rec_en) |-> ck_cnt != '0)
        else $error("release with none held");

endmodule

// File: rtl/reg_rename.sv
module reg_rename import rn_pkg::*; #(
    parameter int unsigned NUM_LOG  = DEF_LOG_REGS,
    parameter int unsigned NUM_PHYS = DEF_PHYS_REGS,
    parameter int unsigned GROUP    = DEF_GROUP,
    parameter int unsigned NUM_CKPT = DEF_CKPTS,
    localparam int unsigned LW      = bits_for(NUM_LOG),
    localparam int unsigned PW      = bits_for(NUM_PHYS),
    localparam int unsigned CW      = bits_for(NUM_CKPT)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        ren_valid,
    output logic                        ren_ready,
    input  logic [GROUP-1:0][LW-1:0]    ren_src_a,
    input  logic [GROUP-1:0][LW-1:0]    ren_src_b,
    input  logic [GROUP-1:0][LW-1:0]    ren_dst,
    input  logic [GROUP-1:0]            ren_dst_en,
    input  logic [GROUP-1:0]            ren_branch,
    output logic [GROUP-1:0][PW-1:0]    out_psrc_a,
    output logic [GROUP-1:0][PW-1:0]    out_psrc_b,
    output logic [GROUP-1:0][PW-1:0]    out_pdst,
    output logic [GROUP-1:0][PW-1:0]    out_pold,
    output logic [CW-1:0]               out_ckpt_id,
    input  logic [GROUP-1:0]            ret_en,
    input  logic [GROUP-1:0][PW-1:0]    ret_tag,
    input  logic                        br_free,
    input  logic                        rec_en,
    input  logic [CW-1:0]               rec_id
);

    localparam int unsigned CNTW = PW + 1;

    logic [NUM_LOG-1:0][PW-1:0] map_q;
    logic [NUM_LOG-1:0][PW-1:0] map_next;
    logic [NUM_LOG-1:0][PW-1:0] snap_map;
    logic [GROUP-1:0][PW-1:0]   peek;
    logic [CNTW-1:0]            head_ptr;
    logic [CNTW-1:0]            free_cnt;
    logic [CNTW-1:0]            need_cnt;
    logic [CNTW-1:0]            snap_head;
    logic [CNTW-1:0]            rec_head;
    logic                       has_branch;
    logic                       ckpt_full;
    logic                       fire;
    stall_e                     stall;

    always_comb begin
        if (rec_en)                        stall = ST_RECOVER;
        else if (free_cnt < need_cnt)      stall = ST_NO_REGS;
        else if (has_branch && ckpt_full)  stall = ST_NO_CKPT;
        else                               stall = ST_GO;
    end

    assign ren_ready = (stall == ST_GO);
    assign fire      = ren_valid && ren_ready;

    rn_group_xlate #(
        .NUM_LOG (NUM_LOG),
        .NUM_PHYS(NUM_PHYS),
        .GROUP   (GROUP)
    ) u_xlate (
        .map_cur   (map_q),
        .src_a     (ren_src_a),
        .src_b     (ren_src_b),
        .dst       (ren_dst),
        .dst_en    (ren_dst_en),
        .branch    (ren_branch),
        .peek      (peek),
        .head_ptr  (head_ptr),
        .psrc_a    (out_psrc_a),
        .psrc_b    (out_psrc_b),
        .pdst      (out_pdst),
        .pold      (out_pold),
        .map_next  (map_next),
        .need_cnt  (need_cnt),
        .has_branch(has_branch),
        .snap_map  (snap_map),
        .snap_head (snap_head)
    );

    rn_free_list #(
        .NUM_LOG (NUM_LOG),
        .NUM_PHYS(NUM_PHYS),
        .GROUP   (GROUP)
    ) u_pool (
        .clk         (clk),
        .rst         (rst),
        .push_en     (ret_en),
        .push_tag    (ret_tag),
        .pop_n       (fire ? need_cnt : '0),
        .restore_en  (rec_en),
        .restore_head(rec_head),
        .peek        (peek),
        .head_ptr    (head_ptr),
        .free_cnt    (free_cnt)
    );

    rn_map_store #(
        .NUM_LOG (NUM_LOG),
        .NUM_PHYS(NUM_PHYS),
        .NUM_CKPT(NUM_CKPT)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .upd_en    (fire),
        .map_next  (map_next),
        .snap_en   (fire && has_branch),
        .snap_map  (snap_map),
        .snap_head (snap_head),
        .release_en(br_free),
        .rec_en    (rec_en),
        .rec_id    (rec_id),
        .map_q     (map_q),
        .ckpt_full (ckpt_full),
        .ckpt_id   (out_ckpt_id),
        .rec_head  (rec_head)
    );

    // R4: tags handed out in one accepted group never collide
    for (genvar a = 0; a < GROUP; a++) begin : g_pair_a
        for (genvar b = a + 1; b < GROUP; b++) begin : g_pair_b
            assert_distinct_dst_R4: assert property (@(posedge clk) disable iff (rst)
                (fire && ren_dst_en[a] && ren_dst_en[b]) |-> out_pdst[a] != out_pdst[b])
                else $error("duplicate destination tag");
        end
    end

    // R6: mapping only moves when a group is accepted or a recovery happens
    assert_map_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!fire && !rec_en) |=> $stable(map_q))
        else $error("mapping changed without acceptance");

endmodule

// File: tb/reg_rename_tb.sv
module reg_rename_tb;

    localparam int NL = 8;
    localparam int NP = 16;
    localparam int W  = 2;
    localparam int NC = 2;
    localparam int LW = 3;
    localparam int PW = 4;
    localparam int CW = 1;

    logic                  clk = 1'b0;
    logic                  rst;
    logic                  ren_valid;
    logic                  ren_ready;
    logic [W-1:0][LW-1:0]  ren_src_a, ren_src_b, ren_dst;
    logic [W-1:0]          ren_dst_en, ren_branch;
    logic [W-1:0][PW-1:0]  out_psrc_a, out_psrc_b, out_pdst, out_pold;
    logic [CW-1:0]         out_ckpt_id;
    logic [W-1:0]          ret_en;
    logic [W-1:0][PW-1:0]  ret_tag;
    logic                  br_free, rec_en;
    logic [CW-1:0]         rec_id;

    reg_rename #(.NUM_LOG(NL), .NUM_PHYS(NP), .GROUP(W), .NUM_CKPT(NC)) u_dut (
        .clk(clk), .rst(rst), .ren_valid(ren_valid), .ren_ready(ren_ready),
        .ren_src_a(ren_src_a), .ren_src_b(ren_src_b), .ren_dst(ren_dst),
        .ren_dst_en(ren_dst_en), .ren_branch(ren_branch),
        .out_psrc_a(out_psrc_a), .out_psrc_b(out_psrc_b), .out_pdst(out_pdst),
        .out_pold(out_pold), .out_ckpt_id(out_ckpt_id),
        .ret_en(ret_en), .ret_tag(ret_tag), .br_free(br_free),
        .rec_en(rec_en), .rec_id(rec_id)
    );

    always #2 clk = ~clk;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // reference state
    int m_map [NL];
    int m_free[$];
    int alloc_log[$];
    int pending[$];
    int pend_base = 0;
    int ck_map [NC][NL];
    int ck_log [NC];
    int ck_pend[NC];
    int ck_old = 0;
    int ck_cnt = 0;

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    task automatic idle();
        ren_valid = 0; ren_src_a = '0; ren_src_b = '0; ren_dst = '0;
        ren_dst_en = '0; ren_branch = '0; ret_en = '0; ret_tag = '0;
        br_free = 0; rec_en = 0; rec_id = '0;
    endtask

    task automatic grp(int j, int a, int b, int d, bit de, bit br);
        ren_valid = 1;
        ren_src_a[j] = LW'(a); ren_src_b[j] = LW'(b); ren_dst[j] = LW'(d);
        ren_dst_en[j] = de; ren_branch[j] = br;
    endtask

    task automatic set_retire(int n);
        for (int j = 0; j < W; j++) begin
            if (j < n && pending.size() > 0) begin
                ret_en[j]  = 1'b1;
                ret_tag[j] = PW'(pending.pop_front());
                pend_base++;
            end
        end
    endtask

    // check combinational outputs mid-cycle, then advance model at the edge
    task automatic commit(string rr, string sr, string dr);
        int  need;
        bit  hb, exp_rdy, fire;
        int  cur[NL];
        bit  wrote[NL];
        int  n;
        #1;
        need = 0; hb = 0;
        for (int j = 0; j < W; j++) begin
            need += int'(ren_dst_en[j]);
            hb |= ren_branch[j];
        end
        exp_rdy = !rec_en && (need <= m_free.size()) && !(hb && ck_cnt == NC);
        chk(rr, "ready", int'(ren_ready), int'(exp_rdy));
        fire = ren_valid && exp_rdy;
        cur = m_map;
        for (int i = 0; i < NL; i++) wrote[i] = 0;
        n = 0;
        if (fire) begin
            for (int j = 0; j < W; j++) begin
                chk(wrote[ren_src_a[j]] ? "R3" : sr, "psrc_a", int'(out_psrc_a[j]), cur[ren_src_a[j]]);
                chk(wrote[ren_src_b[j]] ? "R3" : sr, "psrc_b", int'(out_psrc_b[j]), cur[ren_src_b[j]]);
                if (ren_dst_en[j]) begin
                    chk(dr, "pdst", int'(out_pdst[j]), m_free[n]);
                    chk(wrote[ren_dst[j]] ? "R3" : "R4", "pold", int'(out_pold[j]), cur[ren_dst[j]]);
                    cur[ren_dst[j]] = m_free[n];
                    wrote[ren_dst[j]] = 1;
                    n++;
                end
                if (ren_branch[j]) chk("R8", "ckpt_id", int'(out_ckpt_id), (ck_old + ck_cnt) % NC);
            end
        end
        @(posedge clk);
        if (rec_en) begin
            int r;
            r = int'(rec_id);
            m_map = ck_map[r];
            for (int k = alloc_log.size() - 1; k >= ck_log[r]; k--) begin
                m_free.push_front(alloc_log[k]);
                void'(alloc_log.pop_back());
            end
            while (pend_base + pending.size() > ck_pend[r]) void'(pending.pop_back());
            ck_cnt = (r - ck_old + NC) % NC;
        end else begin
            if (fire) begin
                for (int j = 0; j < W; j++) begin
                    if (ren_dst_en[j]) begin
                        int t;
                        t = m_free.pop_front();
                        alloc_log.push_back(t);
                        pending.push_back(m_map[ren_dst[j]]);
                        m_map[ren_dst[j]] = t;
                    end
                    if (ren_branch[j]) begin
                        int s;
                        s = (ck_old + ck_cnt) % NC;
                        ck_map[s]  = m_map;
                        ck_log[s]  = alloc_log.size();
                        ck_pend[s] = pend_base + pending.size();
                    end
                end
                if (hb) ck_cnt++;
            end
            if (br_free) begin
                ck_old = (ck_old + 1) % NC;
                ck_cnt--;
            end
        end
        for (int j = 0; j < W; j++) if (ret_en[j]) m_free.push_back(int'(ret_tag[j]));
    endtask

    task automatic read_all(string req);
        for (int g = 0; g < NL; g += 2 * W) begin
            @(negedge clk); idle();
            for (int j = 0; j < W; j++) grp(j, g + 2 * j, g + 2 * j + 1, 0, 0, 0);
            commit(req, req, "R4");
        end
    endtask

    task automatic branch_group(string req);
        @(negedge clk); idle();
        grp(0, 1, 2, 0, 0, 0);
        grp(1, 3, 4, 0, 0, 1);
        commit(req, "R2", "R4");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog all act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5150));
        idle();
        rst = 1;
        for (int i = 0; i < NL; i++) m_map[i] = i;
        for (int k = NL; k < NP; k++) m_free.push_back(k);
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R1: identity mapping and first pool tags
        read_all("R1");
        @(negedge clk); idle();
        grp(0, 1, 2, 3, 1, 0);
        grp(1, 3, 0, 3, 1, 0);
        commit("R1", "R2", "R1");

        // R5: slots without a destination leave state untouched
        @(negedge clk); idle();
        grp(0, 3, 5, 5, 0, 0);
        grp(1, 6, 7, 6, 0, 0);
        commit("R5", "R2", "R4");
        read_all("R5");

        // R6: drain the pool, then hold off wider groups
        while (m_free.size() >= W) begin
            @(negedge clk); idle();
            for (int j = 0; j < W; j++) grp(j, $urandom % NL, $urandom % NL, $urandom % NL, 1, 0);
            commit("R6", "R2", "R4");
        end
        @(negedge clk); idle();
        grp(0, 1, 1, 2, 1, 0); grp(1, 2, 2, 4, 1, 0);
        commit("R6", "R2", "R4");
        @(negedge clk); idle();
        grp(0, 1, 1, 2, 1, 0); grp(1, 2, 2, 4, 0, 0);
        commit("R6", "R2", "R4");
        read_all("R6");

        // R7: returned tags are used next
        @(negedge clk); idle();
        grp(0, 1, 1, 2, 1, 0); grp(1, 2, 2, 4, 1, 0);
        set_retire(1);
        commit("R6", "R2", "R4");
        @(negedge clk); idle();
        set_retire(1);
        commit("R7", "R2", "R4");
        @(negedge clk); idle();
        grp(0, 2, 4, 2, 1, 0); grp(1, 2, 4, 4, 1, 0);
        commit("R7", "R2", "R7");
        while (pending.size() > 0) begin
            @(negedge clk); idle();
            set_retire(W);
            commit("R7", "R2", "R4");
        end

        // R8: checkpoints and checkpoint-full stall
        @(negedge clk); idle();
        grp(0, 1, 2, 1, 1, 0); grp(1, 1, 2, 2, 1, 1);
        commit("R8", "R2", "R4");
        @(negedge clk); idle();
        grp(0, 2, 1, 1, 1, 0); grp(1, 1, 2, 4, 1, 0);
        commit("R8", "R2", "R4");
        branch_group("R8");
        branch_group("R8");

        // R9: recover to the oldest checkpoint
        @(negedge clk); idle();
        grp(0, 1, 2, 5, 1, 0);
        rec_en = 1; rec_id = 1'b0;
        commit("R9", "R2", "R4");
        read_all("R9");
        @(negedge clk); idle();
        grp(0, 0, 1, 6, 1, 0); grp(1, 4, 2, 7, 1, 0);
        commit("R9", "R2", "R9");

        // R10: release and partial recovery
        branch_group("R10");
        branch_group("R10");
        branch_group("R10");
        @(negedge clk); idle();
        br_free = 1;
        rec_id = 1'b1;
        commit("R10", "R2", "R4");
        branch_group("R10");
        @(negedge clk); idle();
        rec_en = 1; rec_id = 1'b0;
        br_free = 1;
        commit("R10", "R2", "R4");
        read_all("R10");
        branch_group("R10");
        branch_group("R10");
        @(negedge clk); idle(); br_free = 1; commit("R10", "R2", "R4");
        @(negedge clk); idle(); br_free = 1; commit("R10", "R2", "R4");

        // random traffic without branches
        for (int it = 0; it < 600; it++) begin
            @(negedge clk); idle();
            for (int j = 0; j < W; j++)
                grp(j, $urandom % NL, $urandom % NL, $urandom % NL, 1'($urandom % 2), 0);
            ren_valid = ($urandom % 4) != 0;
            set_retire($urandom % 3);
            commit("R6", "R2", "R4");
        end
        read_all("R2");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule